// File: doc/BRIEF.md
# SPI transmit/receive word queues with programmable depth

This block holds the two data queues of an SPI master: one carries words from software to the serial shifter, the other carries received words back. Each direction has storage for 32 words of 32 bits. The number of entries that may be used at one time, the usable depth, comes from a large-queue enable bit in the control word and the programmed frame size. Software writes words in and reads words out through a small register port. The shifter takes words from the head of the transmit queue and delivers received words into the receive queue.

The block derives the empty, full and one-before-full flags from the queue levels and the current depth, and presents them in a status word. The receive side keeps a sticky overflow flag. This flag is raised when a received word arrives at a full queue, and a read of the receive data register clears it. Serial shifting, chip-select handling and interrupt generation live in neighbouring logic. That logic uses the level outputs, the head word, the pop and push strobes, and the drop pulse.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each direction stores at most 32 words of 32 bits. The levels `tx_level` and `rx_level` are 6 bits wide and never exceed 32.
- R2: Usable depth: when control bit 29 is 0 the depth is 4. When bit 29 is 1, the depth is 32 for a frame size of 8 or less, 16 for a frame size of 9 to 16, and 8 for a frame size above 16.
- R3: After reset the control word reads 0, the frame size reads 4, the depth is 4, both levels are 0, and the status word reads 0x440 (bit 10 and bit 6 set).
- R4: A write to the TX data register while the TX level is at or above the depth is dropped, and the level does not change.
- R5: TX status flags: bit 10 is 1 exactly when the TX level is 0, bit 9 is 1 when the level equals depth−1, and bit 8 is 1 when the level is at or above the depth. Words leave in the order written, and `xfer_tx_word` shows the oldest word.
- R6: A received word (`xfer_rx_push`) that arrives while the RX level is at or above the depth is discarded, `rx_drop` pulses in that cycle, and status bit 2 becomes 1.
- R7: A read of the RX data register returns the oldest word, removes it and clears status bit 2. If the queue is empty, the read returns 0. RX flags: bit 6 is empty, bit 5 is level = depth−1, and bit 4 is level ≥ depth.
- R8: The frame-size register takes a write only while control bit 0 is 0 and the written bits [5:0] are 32 or less. Otherwise it keeps its value.
- R9: The depth follows every control write. Words already stored beyond a smaller new depth are kept, and TX pushes are refused until the level falls below the depth.
- R10: Register word addresses: 0 control (all 32 bits), 1 frame size (bits [5:0], upper bits read 0), 2 status (read-only; writes ignored), 3 RX data, 4 TX data (reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at address 3) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| ctrl_word | output | 32 | Current control word for neighbouring logic |
| xfer_tx_pop | input | 1 | Shifter takes the TX head word |
| xfer_tx_word | output | 32 | Oldest TX word |
| xfer_rx_push | input | 1 | Shifter delivers a received word |
| xfer_rx_word | input | 32 | Received word |
| tx_level | output | 6 | Words held in TX |
| rx_level | output | 6 | Words held in RX |
| rx_drop | output | 1 | Pulse: received word discarded |

## Verification
Eight combinations of the large-queue bit and the frame size are each filled past capacity. These runs separate the three frame-size bands and the small-depth mode, and they catch off-by-one errors at the band edges 8/9 and 16/17. Directed sequences check first-in first-out order on both sides and the one-before-full flag at depth−1. They also run the receive overflow and its clearing by a read, and a read of an empty queue. Frame-size writes are rejected both while the controller is enabled and for an out-of-range value. A final sequence shrinks the depth below the stored level, which shows that stored words survive and that pushes stay blocked until the level drops.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W  = 32;
  localparam int SLOTS   = 32;
  localparam int LVL_W   = $clog2(SLOTS) + 1;
  localparam int FS_W    = 6;
  localparam int FS_MAX  = 32;
  localparam int NARROW_DEPTH = 4;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_FSIZE = 3'd1,
    RA_STAT  = 3'd2,
    RA_RXD   = 3'd3,
    RA_TXD   = 3'd4
  } reg_addr_e;

  localparam int CB_ENABLE = 0;
  localparam int CB_WIDE   = 29;

  localparam int SB_RX_OVF  = 2;
  localparam int SB_RX_FULL = 4;
  localparam int SB_RX_NEAR = 5;
  localparam int SB_RX_EMPTY = 6;
  localparam int SB_TX_FULL = 8;
  localparam int SB_TX_NEAR = 9;
  localparam int SB_TX_EMPTY = 10;

  // Depth from the large-queue bit and the frame size.
  function automatic logic [LVL_W-1:0] usable_depth(input logic wide,
                                                    input logic [FS_W-1:0] fsz);
    if (!wide)        return LVL_W'(NARROW_DEPTH);
    else if (fsz <= 8)  return LVL_W'(SLOTS);
    else if (fsz <= 16) return LVL_W'(SLOTS / 2);
    else                return LVL_W'(SLOTS / 4);
  endfunction

  // {near, full, empty} for one queue.
  function automatic logic [2:0] level_flags(input logic [LVL_W-1:0] lvl,
                                             input logic [LVL_W-1:0] dep);
    return {lvl == dep - LVL_W'(1), lvl >= dep, lvl == '0};
  endfunction
endpackage

// File: rtl/spi_fifo_queue.sv
module spi_fifo_queue #(
  parameter int DW    = 32,
  parameter int CAP   = 32,
  parameter int LW    = $clog2(CAP) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] limit,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          drop
);
  localparam int AW = $clog2(CAP);

  logic [DW-1:0] mem [CAP];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push_req && (level < limit);
  assign pop_ok  = pop_req && (level != '0);
  assign drop    = push_req && !push_ok;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import spi_fifo_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] depth,
  input  logic          ovf,
  output logic [31:0]   status
);
  logic [2:0] txf, rxf;
  assign txf = level_flags(tx_lvl, depth);
  assign rxf = level_flags(rx_lvl, depth);

  always_comb begin
    status              = '0;
    status[SB_RX_OVF]   = ovf;
    status[SB_RX_EMPTY] = rxf[0];
    status[SB_RX_FULL]  = rxf[1];
    status[SB_RX_NEAR]  = rxf[2];
    status[SB_TX_EMPTY] = txf[0];
    status[SB_TX_FULL]  = txf[1];
    status[SB_TX_NEAR]  = txf[2];
  end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CAP = SLOTS,
  localparam int LW = $clog2(CAP) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] ctrl_word,
  input  logic          xfer_tx_pop,
  output logic [DW-1:0] xfer_tx_word,
  input  logic          xfer_rx_push,
  input  logic [DW-1:0] xfer_rx_word,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          rx_drop
);
  reg_addr_e       sel;
  logic [DW-1:0]   ctrl_q;
  logic [FS_W-1:0] fs_q;
  logic            ovf_q;
  logic [LW-1:0]   depth_now;
  logic [31:0]     status_w;
  logic [DW-1:0]   rx_head;
  logic            wr_ctrl, wr_fs, wr_txd, rd_rxd, fs_take;
  logic            tx_drop_unused;

  assign sel     = reg_addr_e'(reg_addr);
  assign wr_ctrl = reg_wr && (sel == RA_CTRL);
  assign wr_fs   = reg_wr && (sel == RA_FSIZE);
  assign wr_txd  = reg_wr && (sel == RA_TXD);
  assign rd_rxd  = reg_rd && (sel == RA_RXD);
  assign fs_take = wr_fs && !ctrl_q[CB_ENABLE] &&
                   (reg_wdata[FS_W-1:0] <= FS_W'(FS_MAX));

  assign depth_now = LW'(usable_depth(ctrl_q[CB_WIDE], fs_q));
  assign ctrl_word = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fs_q   <= FS_W'(4);
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (fs_take) fs_q   <= reg_wdata[FS_W-1:0];
      if (rx_drop)     ovf_q <= 1'b1;
      else if (rd_rxd) ovf_q <= 1'b0;
    end
  end

  spi_fifo_queue #(.DW(DW), .CAP(CAP), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_req(wr_txd), .pop_req(xfer_tx_pop), .din(reg_wdata),
    .limit(depth_now), .dout(xfer_tx_word), .level(tx_level),
    .drop(tx_drop_unused)
  );

  spi_fifo_queue #(.DW(DW), .CAP(CAP), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_req(xfer_rx_push), .pop_req(rd_rxd), .din(xfer_rx_word),
    .limit(depth_now), .dout(rx_head), .level(rx_level),
    .drop(rx_drop)
  );

  spi_fifo_flags #(.LW(LW)) u_flags (
    .tx_lvl(tx_level), .rx_lvl(rx_level), .depth(depth_now),
    .ovf(ovf_q), .status(status_w)
  );

  always_comb begin
    case (sel)
      RA_CTRL:  reg_rdata = ctrl_q;
      RA_FSIZE: reg_rdata = DW'(fs_q);
      RA_STAT:  reg_rdata = DW'(status_w);
      RA_RXD:   reg_rdata = (rx_level == '0) ? '0 : rx_head;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_checker.sv
module spi_fifo_checker #(
  parameter int CAP = 32,
  parameter int LW  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          xfer_tx_pop,
  input logic          xfer_rx_push,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] depth_now,
  input logic [31:0]   status_w,
  input logic [5:0]    fs_q,
  input logic          ctrl_en
);
  // R1
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(CAP)) && (rx_level <= LW'(CAP)));

  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && tx_level >= depth_now && !xfer_tx_pop)
      |=> $stable(tx_level));

  // R5
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) == status_w[10]);

  // R6
  rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_rx_push && rx_level >= depth_now) |=> status_w[2]);

  // R7
  rx_ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd3 && !(xfer_rx_push && rx_level >= depth_now))
      |=> !status_w[2]);

  // R8
  fs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && ctrl_en) |=> $stable(fs_q));
endmodule

bind spi_fifo_pair spi_fifo_checker #(.CAP(CAP), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .xfer_tx_pop(xfer_tx_pop), .xfer_rx_push(xfer_rx_push),
  .tx_level(tx_level), .rx_level(rx_level), .depth_now(depth_now),
  .status_w(status_w), .fs_q(fs_q), .ctrl_en(ctrl_q[0])
);

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, ctrl_word, xfer_tx_word;
  logic        xfer_tx_pop = 1'b0, xfer_rx_push = 1'b0;
  logic [31:0] xfer_rx_word = '0;
  logic [5:0]  tx_level, rx_level;
  logic        rx_drop;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  spi_fifo_pair dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl_word(ctrl_word), .xfer_tx_pop(xfer_tx_pop), .xfer_tx_word(xfer_tx_word),
    .xfer_rx_push(xfer_rx_push), .xfer_rx_word(xfer_rx_word),
    .tx_level(tx_level), .rx_level(rx_level), .rx_drop(rx_drop)
  );

  // {wide bit, frame size, expected depth}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 6'd4,  6'd4},  {1'b0, 6'd20, 6'd4},
    {1'b1, 6'd1,  6'd32}, {1'b1, 6'd8,  6'd32},
    {1'b1, 6'd9,  6'd16}, {1'b1, 6'd16, 6'd16},
    {1'b1, 6'd17, 6'd8},  {1'b1, 6'd32, 6'd8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic txpop();
    @(negedge clk);
    xfer_tx_pop = 1'b1;
    @(negedge clk);
    xfer_tx_pop = 1'b0;
  endtask

  task automatic rxpush(input logic [31:0] d, output logic dropped);
    @(negedge clk);
    xfer_rx_push = 1'b1; xfer_rx_word = d;
    #1 dropped = rx_drop;
    @(negedge clk);
    xfer_rx_push = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic dr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    peek(3'd2, v); check("R3 status", v, 32'h440);
    peek(3'd0, v); check("R3 ctrl", v, 32'h0);
    peek(3'd1, v); check("R3 fsize", v, 32'd4);
    check("R3 levels", {26'd0, tx_level} | {26'd0, rx_level}, 32'd0);

    // R2 R4 depth table walk
    for (int i = 0; i < 8; i++) begin
      logic [5:0] dep;
      dep = VEC[i][5:0];
      wr(3'd0, {2'b0, VEC[i][12], 29'd0});
      wr(3'd1, {26'd0, VEC[i][11:6]});
      for (int k = 0; k <= int'(dep); k++) wr(3'd4, 32'h100 + k);
      check($sformatf("R2 depth vec%0d", i), {26'd0, tx_level}, {26'd0, dep});
      peek(3'd2, v); check($sformatf("R4 full flag vec%0d", i), {31'd0, v[8]}, 32'd1);
      for (int k = 0; k < int'(dep); k++) txpop();
      check($sformatf("R5 drained vec%0d", i), {26'd0, tx_level}, 32'd0);
    end

    // back to small depth 4
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd4);

    // R5 flags and order
    wr(3'd4, 32'hAAAA0001); wr(3'd4, 32'hAAAA0002); wr(3'd4, 32'hAAAA0003);
    peek(3'd2, v);
    check("R5 near set", {31'd0, v[9]}, 32'd1);
    check("R5 full clear", {31'd0, v[8]}, 32'd0);
    check("R5 empty clear", {31'd0, v[10]}, 32'd0);
    check("R5 head", xfer_tx_word, 32'hAAAA0001);
    txpop();
    check("R5 next head", xfer_tx_word, 32'hAAAA0002);
    txpop(); txpop();
    peek(3'd2, v); check("R5 empty again", {31'd0, v[10]}, 32'd1);

    // R10 status write ignored, TX data reads 0
    wr(3'd2, 32'hFFFF_FFFF);
    peek(3'd2, v); check("R10 status ro", v, 32'h440);
    peek(3'd4, v); check("R10 txd reads 0", v, 32'h0);

    // R6 R7 receive side
    for (int k = 0; k < 4; k++) begin
      rxpush(32'hA1 + k, dr);
      check("R6 no drop below depth", {31'd0, dr}, 32'd0);
    end
    peek(3'd2, v); check("R7 rx full", {31'd0, v[4]}, 32'd1);
    rxpush(32'hA5, dr);
    check("R6 drop pulse", {31'd0, dr}, 32'd1);
    check("R6 level kept", {26'd0, rx_level}, 32'd4);
    peek(3'd2, v); check("R6 ovf set", {31'd0, v[2]}, 32'd1);
    rd(3'd3, v); check("R7 oldest", v, 32'hA1);
    peek(3'd2, v);
    check("R7 ovf cleared", {31'd0, v[2]}, 32'd0);
    check("R7 full cleared", {31'd0, v[4]}, 32'd0);
    check("R7 near set", {31'd0, v[5]}, 32'd1);
    rd(3'd3, v); check("R7 second", v, 32'hA2);
    rd(3'd3, v); check("R7 third", v, 32'hA3);
    rd(3'd3, v); check("R7 fourth", v, 32'hA4);
    peek(3'd2, v); check("R7 rx empty", {31'd0, v[6]}, 32'd1);
    rd(3'd3, v); check("R7 empty read zero", v, 32'h0);
    check("R1 rx level zero", {26'd0, rx_level}, 32'd0);

    // R8 frame-size lock and range
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd10);
    peek(3'd1, v); check("R8 locked when enabled", v, 32'd4);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd33);
    peek(3'd1, v); check("R8 reject above 32", v, 32'd4);
    wr(3'd1, 32'hFFFF_FF10);
    peek(3'd1, v); check("R8 accept low bits", v, 32'd16);
    wr(3'd1, 32'd4);

    // R9 depth shrink keeps stored words
    wr(3'd0, 32'h2000_0000);
    peek(3'd0, v); check("R10 ctrl readback", v, 32'h2000_0000);
    for (int k = 0; k < 10; k++) wr(3'd4, 32'h200 + k);
    check("R9 ten stored", {26'd0, tx_level}, 32'd10);
    wr(3'd0, 32'h0);
    check("R9 words kept", {26'd0, tx_level}, 32'd10);
    wr(3'd4, 32'hDEAD);
    check("R9 push blocked", {26'd0, tx_level}, 32'd10);
    peek(3'd2, v); check("R9 full above depth", {31'd0, v[8]}, 32'd1);
    for (int k = 0; k < 7; k++) txpop();
    check("R9 head order", xfer_tx_word, 32'h207);
    wr(3'd4, 32'hBEEF);
    check("R9 push after drain", {26'd0, tx_level}, 32'd4);
    check("R1 ctrl out", ctrl_word, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule